// File: doc/BRIEF.md
# Blanking-Aware Sample Output Pipeline

This block sits between a converter model and the parallel sample output of an imaging front end. Each ADC clock edge it captures one sample word and delivers it on the output a fixed number of edges later. In normal running the delay is nine edges.

An active-low blanking input marks samples taken during noisy intervals. Each captured word carries its blanking flag down the pipeline. A blanked word reaches the output as an all-zero word. While any blanked word is still in flight, the output reads from a deeper tap, so the delay grows to eleven edges. When the last blanked word has left, the output returns to the nine-edge tap. It goes straight from the final zero word to valid data, with no stale word between them.

A standby control forces the output to zero on the next edge. Standby overrides blanking. The pipeline keeps advancing underneath it. A sample-valid strobe marks real samples; a word captured while the strobe is low travels as zero.

Top module: `pblk_data_pipe`

## Requirements
- R1: `rst` is synchronous and active high. After any edge at which `rst` is high, `dout` is zero and every stored word and blanking flag is cleared to zero, meaning unblanked.
- R2: If `blank_n` was high at each of the 11 edges before edge t, `dout` after edge t carries the word captured at edge t-9.
- R3: If `blank_n` was low at any of the 11 edges before edge t, `dout` after edge t carries the word captured at edge t-11, or zero if that word was blanked.
- R4: A word captured at an edge where `blank_n` is low reaches `dout` as all zeros. If the first low sample of `blank_n` is at edge k, `dout` is zero after edge k+11.
- R5: `blank_n` high means blanking is off and low means blanking is on. A word captured with `blank_n` high keeps its value.
- R6: After a blanking interval, once 11 consecutive edges have sampled `blank_n` high, the nine-edge delay of R2 is in force again. The edge after the last zero word already shows a normal-delay word.
- R7: After any edge at which `standby` is high, `dout` is zero, whatever the blanking state. Standby does not stall the stored pipeline contents.
- R8: A word captured while `smp_vld` is low is carried as zero.
- R9: The data path is `DATA_W` bits wide, 10 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | DATA_W | Raw converted sample word |
| smp_vld | input | 1 | Sample-valid strobe; low makes the captured word zero |
| blank_n | input | 1 | Active-low input blanking |
| standby | input | 1 | Forces the output to zero on the next edge |
| dout | output | DATA_W | Registered delayed sample word |

## Verification
The bench builds the block with its defaults: a 10-bit word, a normal delay of 9 and a blanking delay of 11. The gap of only two taps between the two delays makes every switch between modes observable. Blanking pulses from one edge up to many times the pipeline depth are driven. This covers entering blanking with real words still in flight, short pulses that hold the deep tap only briefly, and release with its two-word skip. Standby is applied both inside and outside blanking windows, so its priority is exercised in every mode.

// File: rtl/pblk_pkg.sv
package pblk_pkg;
  localparam int unsigned DEF_DATA_W    = 10;
  localparam int unsigned DEF_LAT_NORM  = 9;
  localparam int unsigned DEF_LAT_BLANK = 11;
endpackage

// File: rtl/pblk_delay_line.sv
module pblk_delay_line #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   tap
);
  // tap[j] holds the word captured j+1 edges ago
  always_ff @(posedge clk) begin
    if (rst) tap[0] <= '0;
    else     tap[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap[g] <= '0;
      else     tap[g] <= tap[g-1];
    end
  end
endmodule

// File: rtl/pblk_out_sel.sv
module pblk_out_sel #(
  parameter int unsigned W         = 10,
  parameter int unsigned LAT_NORM  = 9,
  parameter int unsigned LAT_BLANK = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          standby,
  input  logic [LAT_BLANK-1:0][W-1:0]   dtap,
  input  logic [LAT_BLANK-1:0]          btap,
  output logic [W-1:0]                  dout
);
  logic          win;
  logic [W-1:0]  nxt;

  assign win = |btap;

  always_comb begin
    if (standby)                nxt = '0;
    else if (!win)              nxt = dtap[LAT_NORM-1];
    else if (btap[LAT_BLANK-1]) nxt = '0;
    else                        nxt = dtap[LAT_BLANK-1];
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= nxt;
  end
endmodule

// File: rtl/pblk_data_pipe.sv
module pblk_data_pipe #(
  parameter int unsigned DATA_W    = pblk_pkg::DEF_DATA_W,
  parameter int unsigned LAT_NORM  = pblk_pkg::DEF_LAT_NORM,
  parameter int unsigned LAT_BLANK = pblk_pkg::DEF_LAT_BLANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              smp_vld,
  input  logic              blank_n,
  input  logic              standby,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned DEPTH = LAT_BLANK;

  logic [DATA_W-1:0]             word_in;
  logic [DEPTH-1:0][DATA_W-1:0]  dtap;
  logic [DEPTH-1:0][0:0]         btap_w;
  logic [DEPTH-1:0]              btap;

  assign word_in = smp_vld ? smp_in : '0;

  pblk_delay_line #(.W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .din(word_in), .tap(dtap)
  );

  pblk_delay_line #(.W(1), .DEPTH(DEPTH)) u_flag (
    .clk(clk), .rst(rst), .din(~blank_n), .tap(btap_w)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign btap[g] = btap_w[g][0];
  end

  pblk_out_sel #(.W(DATA_W), .LAT_NORM(LAT_NORM), .LAT_BLANK(LAT_BLANK)) u_sel (
    .clk(clk), .rst(rst), .standby(standby),
    .dtap(dtap), .btap(btap), .dout(dout)
  );
endmodule

// File: rtl/pblk_data_pipe_chk.sv
module pblk_data_pipe_chk #(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned LAT_BLANK = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] smp_in,
  input logic              smp_vld,
  input logic              blank_n,
  input logic              standby,
  input logic [DATA_W-1:0] dout
);
  logic [7:0] lo_run;
  logic [7:0] zero_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run   <= '0;
      zero_run <= '0;
    end else begin
      if (blank_n)            lo_run <= '0;
      else if (lo_run != '1)  lo_run <= lo_run + 8'd1;
      if (smp_vld && smp_in != '0) zero_run <= '0;
      else if (zero_run != '1)     zero_run <= zero_run + 8'd1;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> dout == '0);

  // R7
  standby_zero_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> dout == '0);

  // R4
  long_blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_run >= 8'(LAT_BLANK)) |=> dout == '0);

  // R8
  zero_input_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_run >= 8'(LAT_BLANK)) |=> dout == '0);
endmodule

bind pblk_data_pipe pblk_data_pipe_chk #(.DATA_W(DATA_W), .LAT_BLANK(LAT_BLANK)) chk_i (
  .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
  .blank_n(blank_n), .standby(standby), .dout(dout)
);

// File: tb/pblk_data_pipe_tb.sv
module pblk_data_pipe_tb_top;
  localparam int W  = 10;
  localparam int LN = 9;
  localparam int LB = 11;

  logic         clk = 0;
  logic         rst = 1;
  logic [W-1:0] smp_in = '0;
  logic         smp_vld = 0;
  logic         blank_n = 1;
  logic         standby = 0;
  logic [W-1:0] dout;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pblk_data_pipe dut_i (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
    .blank_n(blank_n), .standby(standby), .dout(dout)
  );

  // bench history: index j = captured j edges ago
  logic [W-1:0] h_d [0:LB];
  logic         h_b [0:LB];
  logic         h_v [0:LB];
  logic [W-1:0] exp_q = '0;
  string        exp_tag = "R1";
  bit           prev_win = 0;

  function automatic bit win_now();
    bit w = 0;
    for (int j = 1; j <= LB; j++) w |= h_b[j];
    return w;
  endfunction

  always @(posedge clk) begin
    bit w;
    w = win_now();
    if (rst) begin
      exp_q   <= '0;
      exp_tag <= "R1";
      prev_win <= 0;
      for (int j = 0; j <= LB; j++) begin h_d[j] <= '0; h_b[j] <= 0; h_v[j] <= 1; end
    end else begin
      if (standby) begin
        exp_q <= '0; exp_tag <= "R7";
      end else if (w) begin
        exp_q   <= h_b[LB] ? '0 : h_d[LB];
        exp_tag <= h_b[LB] ? "R4" : (h_v[LB] ? "R3" : "R8");
      end else begin
        exp_q   <= h_d[LN];
        exp_tag <= prev_win ? "R6" : (h_v[LN] ? "R2 R5" : "R8");
      end
      prev_win <= w;
      h_d[1] <= smp_vld ? smp_in : '0;
      h_b[1] <= ~blank_n;
      h_v[1] <= smp_vld;
      for (int j = 2; j <= LB; j++) begin
        h_d[j] <= h_d[j-1]; h_b[j] <= h_b[j-1]; h_v[j] <= h_v[j-1];
      end
    end
  end

  task automatic check_out();
    total++;
    if (dout !== exp_q) begin
      bad++;
      $display("FAIL %s: dout=%0h expected=%0h at %0t", exp_tag, dout, exp_q, $time);
    end
  endtask

  always @(negedge clk) if (!done && total_en) check_out();
  bit total_en = 0;

  task automatic step(input logic [W-1:0] d, input bit v, input bit bn, input bit sb);
    @(negedge clk);
    smp_in = d; smp_vld = v; blank_n = bn; standby = sb;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    total_en = 1;          // reset-state checks (R1)
    @(negedge clk);
    total++;
    if ($bits(dout) != 10) begin
      bad++; $display("FAIL R9: width=%0d expected=10", $bits(dout));
    end
    rst = 0;
    // R2 R5: counting pattern, no blanking
    for (int i = 0; i < 30; i++) step(W'(i + 1), 1, 1, 0);
    // R4 R3: long blank
    for (int i = 0; i < 30; i++) step(W'(100 + i), 1, 0, 0);
    // R6: release
    for (int i = 0; i < 25; i++) step(W'(200 + i), 1, 1, 0);
    // short one-edge blank pulse
    step(W'(300), 1, 0, 0);
    for (int i = 0; i < 20; i++) step(W'(301 + i), 1, 1, 0);
    // R7: standby inside and outside blanking
    for (int i = 0; i < 5; i++) step(W'(400 + i), 1, 1, 1);
    for (int i = 0; i < 5; i++) step(W'(410 + i), 1, 0, 1);
    for (int i = 0; i < 15; i++) step(W'(420 + i), 1, 1, 0);
    // R8: invalid words
    for (int i = 0; i < 15; i++) step(W'(500 + i), i[0], 1, 0);
    // mid-run reset (R1)
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    // random mix
    for (int i = 0; i < 3000; i++)
      step(W'($urandom), ($urandom % 8) != 0, ($urandom % 6) != 0, ($urandom % 25) == 0);
    for (int i = 0; i < 20; i++) step(W'(i), 1, 1, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule